// File: doc/BRIEF.md
# Rotating Arbitration Rank Tracker

This block keeps the arbitration rank of one agent on a shared interrupt message bus where every agent carries its own self-rotating priority number. Each time a message on the bus finishes, the bus logic presents a one-cycle outcome strobe with four pieces of information. These are the rank of the agent that won the bus, whether that winner was this agent, whether the message was of the low-priority delivery kind, and whether it finished free of checksum and acceptance errors. From this outcome the tracker moves its own rank. The winner falls to rank 0. A non-winner below the top rank climbs by one. A non-winner at the top rank wraps to the winner's former rank plus one.

Software names the agent by writing an identity value, and that write also seeds the rank. A separate strobe, raised when an INIT-deassert message is received, puts the rank back to the stored identity. The bit-level bus contention and the message framing belong to neighbouring logic. This block only holds and advances the rank number that such logic uses.

Top module: `arb_rank_tracker`

## Requirements
- R1: While reset is asserted, and right after it is released, both the stored identity and the rank read 0.
- R2: On an outcome strobe that is eligible for update and that reports this agent as the winner, the rank becomes 0 on the next clock.
- R3: On an eligible strobe where this agent lost and its rank is below the all-ones value (15 at the default 4-bit width), the rank increases by one.
- R4: On an eligible strobe where this agent lost and its rank is all-ones, the rank becomes the reported winner rank plus one, taken modulo 2^ID_W (a winner rank of 15 gives 0).
- R5: A strobe is eligible when its error-free flag is 1. A strobe whose error-free flag and low-priority flag are both 0 leaves the rank unchanged.
- R6: A strobe with the low-priority flag at 1 is eligible even when its error-free flag is 0, and it updates the rank by R2 to R4.
- R7: An identity write stores the written value as the identity and, on the same clock, loads that value into the rank.
- R8: An INIT-deassert strobe loads the rank from the stored identity and leaves the identity unchanged.
- R9: When several events share a cycle, the identity write wins over INIT-deassert, and INIT-deassert wins over an outcome strobe. Only the winning event takes effect.
- R10: In a cycle with no write, no INIT-deassert and no outcome strobe, the rank and the identity hold their values. Each strobe cycle applies exactly one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_wr_en | input | 1 | Identity write strobe |
| id_wr_data | input | ID_W | Value to store as identity and rank |
| init_deassert | input | 1 | INIT-deassert message received strobe |
| msg_done | input | 1 | One-cycle message outcome strobe |
| msg_winner_rank | input | ID_W | Rank the winner held before the update |
| msg_self_won | input | 1 | 1 when this agent won the message |
| msg_low_prio | input | 1 | 1 when the message used low-priority delivery |
| msg_clean | input | 1 | 1 when no checksum or acceptance error was reported |
| self_id | output | ID_W | Stored identity |
| arb_rank | output | ID_W | Current arbitration rank |

## Verification
The bench steers the rank to all-ones and checks the wrap against several winner ranks, including 14, which must give 15, and 15, which must give 0. A design that simply incremented the rank would roll over to 0 instead, and one that dropped the carry would land on the wrong value. Failed messages are sent with the low-priority flag both set and clear. A design that gated the low-priority case on success would freeze the rank, and one that ignored the error flag would move it. Coinciding write, INIT-deassert and outcome strobes expose a wrong precedence, because each source leads to a different rank value.

// File: rtl/arb_rank_pkg.sv
package arb_rank_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_WRITE  = 2'd1,
        SRC_INIT   = 2'd2,
        SRC_ROTATE = 2'd3
    } rank_src_e;

endpackage

// File: rtl/arb_rank_select.sv
module arb_rank_select
    import arb_rank_pkg::*;
(
    input  logic      wr_en,
    input  logic      init_hit,
    input  logic      done,
    input  logic      low_prio,
    input  logic      clean,
    output rank_src_e src
);
    logic eligible;

    always_comb begin
        eligible = done && (clean || low_prio);
        if (wr_en)         src = SRC_WRITE;
        else if (init_hit) src = SRC_INIT;
        else if (eligible) src = SRC_ROTATE;
        else               src = SRC_HOLD;
    end
endmodule

// File: rtl/arb_rank_rotate.sv
module arb_rank_rotate #(
    parameter int ID_W = 4
) (
    input  logic [ID_W-1:0] cur_rank,
    input  logic [ID_W-1:0] winner_rank,
    input  logic            self_won,
    output logic [ID_W-1:0] next_rank
);
    localparam logic [ID_W-1:0] TOP = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] ONE = ID_W'(1);

    always_comb begin
        if (self_won)             next_rank = '0;
        else if (cur_rank == TOP) next_rank = winner_rank + ONE;
        else                      next_rank = cur_rank + ONE;
    end
endmodule

// File: rtl/arb_rank_tracker.sv
module arb_rank_tracker
    import arb_rank_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_wr_en,
    input  logic [ID_W-1:0] id_wr_data,
    input  logic            init_deassert,
    input  logic            msg_done,
    input  logic [ID_W-1:0] msg_winner_rank,
    input  logic            msg_self_won,
    input  logic            msg_low_prio,
    input  logic            msg_clean,
    output logic [ID_W-1:0] self_id,
    output logic [ID_W-1:0] arb_rank
);
    typedef struct packed {
        logic [ID_W-1:0] ident;
        logic [ID_W-1:0] rank;
    } state_t;

    state_t          st_d, st_q;
    rank_src_e       src;
    logic [ID_W-1:0] rotated;

    arb_rank_select u_sel (
        .wr_en    (id_wr_en),
        .init_hit (init_deassert),
        .done     (msg_done),
        .low_prio (msg_low_prio),
        .clean    (msg_clean),
        .src      (src)
    );

    arb_rank_rotate #(.ID_W(ID_W)) u_rot (
        .cur_rank    (st_q.rank),
        .winner_rank (msg_winner_rank),
        .self_won    (msg_self_won),
        .next_rank   (rotated)
    );

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_WRITE: begin
                st_d.ident = id_wr_data;
                st_d.rank  = id_wr_data;
            end
            SRC_INIT:   st_d.rank = st_q.ident;
            SRC_ROTATE: st_d.rank = rotated;
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign self_id  = st_q.ident;
    assign arb_rank = st_q.rank;
endmodule

// File: rtl/arb_rank_chk.sv
module arb_rank_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_wr_en,
    input logic [ID_W-1:0] id_wr_data,
    input logic            init_deassert,
    input logic            msg_done,
    input logic [ID_W-1:0] msg_winner_rank,
    input logic            msg_self_won,
    input logic            msg_low_prio,
    input logic            msg_clean,
    input logic [ID_W-1:0] self_id,
    input logic [ID_W-1:0] arb_rank
);
    localparam logic [ID_W-1:0] TOP = {ID_W{1'b1}};

    logic quiet, elig;
    assign quiet = !id_wr_en && !init_deassert;
    assign elig  = msg_done && (msg_clean || msg_low_prio);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (arb_rank == '0 && self_id == '0); // R1
        end
    end

    AST_WIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && elig && msg_self_won |=> arb_rank == '0); // R2

    AST_LOSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && elig && !msg_self_won && arb_rank != TOP
        |=> arb_rank == ID_W'($past(arb_rank) + 1'b1)); // R3

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && elig && !msg_self_won && arb_rank == TOP
        |=> arb_rank == ID_W'($past(msg_winner_rank) + 1'b1)); // R4

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && msg_done && !msg_clean && !msg_low_prio |=> $stable(arb_rank)); // R5

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr_en |=> arb_rank == $past(id_wr_data) && self_id == $past(id_wr_data)); // R7

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init_deassert && !id_wr_en |=> arb_rank == $past(self_id) && $stable(self_id)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && !msg_done |=> $stable(arb_rank) && $stable(self_id)); // R10
endmodule

bind arb_rank_tracker arb_rank_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/sim_arb_rank_tracker.sv
module sim_arb_rank_tracker;
    localparam int ID_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            id_wr_en = 1'b0;
    logic [ID_W-1:0] id_wr_data = '0;
    logic            init_deassert = 1'b0;
    logic            msg_done = 1'b0;
    logic [ID_W-1:0] msg_winner_rank = '0;
    logic            msg_self_won = 1'b0;
    logic            msg_low_prio = 1'b0;
    logic            msg_clean = 1'b0;
    logic [ID_W-1:0] self_id;
    logic [ID_W-1:0] arb_rank;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic [ID_W-1:0] m_id = '0;
    logic [ID_W-1:0] m_rank = '0;

    always #4 clk = ~clk;

    arb_rank_tracker #(.ID_W(ID_W)) u0 (.*);

    function automatic logic [ID_W-1:0] exp_rank(
        input logic [ID_W-1:0] r, input logic [ID_W-1:0] id,
        input logic wr, input logic [ID_W-1:0] wd, input logic ini,
        input logic dn, input logic won, input logic lp, input logic ok,
        input logic [ID_W-1:0] win);
        if (wr) return wd;
        if (ini) return id;
        if (dn && (ok || lp)) begin
            if (won) return '0;
            if (r == 4'd15) return win + 4'd1;
            return r + 4'd1;
        end
        return r;
    endfunction

    function automatic string tag_of(
        input logic [ID_W-1:0] r, input logic wr, input logic ini,
        input logic dn, input logic won, input logic lp, input logic ok);
        if (wr && (ini || dn)) return "R9";
        if (wr) return "R7";
        if (ini && dn) return "R9";
        if (ini) return "R8";
        if (!dn) return "R10";
        if (!ok && !lp) return "R5";
        if (!ok) return "R6";
        if (won) return "R2";
        if (r == 4'd15) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [ID_W-1:0] act,
                         input logic [ID_W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [ID_W-1:0] wd, input logic ini,
                        input logic dn, input logic won, input logic lp, input logic ok,
                        input logic [ID_W-1:0] win);
        string t;
        t = tag_of(m_rank, wr, ini, dn, won, lp, ok);
        id_wr_en = wr; id_wr_data = wd; init_deassert = ini;
        msg_done = dn; msg_self_won = won; msg_low_prio = lp;
        msg_clean = ok; msg_winner_rank = win;
        m_rank = exp_rank(m_rank, m_id, wr, wd, ini, dn, won, lp, ok, win);
        if (wr) m_id = wd;
        @(negedge clk);
        id_wr_en = 1'b0; init_deassert = 1'b0; msg_done = 1'b0;
        check(t, arb_rank, m_rank, "rank");
        check(t, self_id, m_id, "identity");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", arb_rank, '0, "rank in reset");
        check("R1", self_id, '0, "identity in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", arb_rank, '0, "rank after reset");

        step(1, 4'd9, 0, 0, 0, 0, 0, 4'd0);   // R7 load 9
        step(0, 4'd0, 0, 1, 0, 0, 1, 4'd3);   // R3 9 -> 10
        step(0, 4'd0, 0, 1, 0, 0, 0, 4'd3);   // R5 failed, hold
        step(0, 4'd0, 0, 1, 0, 1, 0, 4'd3);   // R6 low prio failed, moves
        step(0, 4'd0, 0, 1, 1, 0, 1, 4'd3);   // R2 drop to 0
        step(1, 4'd15, 0, 0, 0, 0, 0, 4'd0);  // R7 load 15
        step(0, 4'd0, 0, 1, 0, 0, 1, 4'd14);  // R4 wrap 14 -> 15
        step(0, 4'd0, 0, 1, 0, 0, 1, 4'd15);  // R4 wrap 15 -> 0
        step(0, 4'd0, 1, 0, 0, 0, 0, 4'd0);   // R8 back to 15
        step(0, 4'd0, 0, 1, 0, 0, 1, 4'd6);   // R4 wrap 6 -> 7
        step(1, 4'd4, 1, 1, 1, 0, 1, 4'd2);   // R9 write over all
        step(0, 4'd0, 0, 1, 0, 0, 1, 4'd2);   // R3 4 -> 5
        step(0, 4'd0, 1, 1, 1, 0, 1, 4'd2);   // R9 init over message
        step(0, 4'd0, 0, 0, 1, 1, 1, 4'd7);   // R10 flags without strobe
        step(0, 4'd0, 0, 1, 0, 1, 1, 4'd7);   // R6 low prio clean

        void'($urandom(32'h5eed_0a1b));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] p;
            p = 8'($urandom_range(0, 255));
            step(p < 8'd10, 4'($urandom), p inside {[8'd10:8'd20]}, p > 8'd60,
                 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 3) != 0),
                 4'($urandom));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule